// File: doc/BRIEF.md
# ROM Wait-State Sequencer

This block paces 16-bit word reads from an on-chip read-only memory. A requester presents a word address and a source tag on a ready/valid request port. The sequencer drives a synchronous ROM array through an enable and an address. It returns the word, together with the original tag, as a single-cycle response. Requests reaching this block have already been decoded to the internal ROM, and arbitration between requesters happens upstream.

The latency is asymmetric. A word fetched from idle takes three cycles. A word that continues a run takes two cycles. A run continues only when the next request is accepted in the same cycle that the previous word is returned. A software-controlled ROM-disable input cancels any access in flight and holds the sequencer idle for as long as it is set. Wait counts, address width and tag width are parameters.

Top module: `rom_wait_seq`

## Requirements
- R1: After reset (with `rom_off` low), `rsp_valid` and `rom_en` are 0 and `req_ready` is 1.
- R2: A request accepted while the sequencer is idle produces `rsp_valid` exactly 3 cycles after the accepting cycle (first access).
- R3: A request accepted in a cycle where `rsp_valid` is high produces its response exactly 2 cycles later (subsequent access).
- R4: If at least one cycle without acceptance follows a response, the next accepted request is again a first access with 3-cycle latency.
- R5: `rsp_valid` is high for exactly one cycle per accepted word, and `req_ready` is 0 in every wait cycle of an access.
- R6: `rom_en` pulses for one cycle, with `rom_addr` equal to the accepted word address, in the cycle before `rsp_valid`, and `rsp_data` equals the ROM word at that address.
- R7: `rsp_src` returns the tag given with the request. Tag values 0 (program bus), 1 (data bus), 2 (DMA) and 3 are all carried unchanged.
- R8: While `rom_off` is high, `req_ready` is 0. From the cycle after `rom_off` rises, no response is produced for an access that was in flight.
- R9: After `rom_off` returns low, the next accepted request is a first access with 3-cycle latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rom_off | input | 1 | ROM disable; aborts and blocks accesses while high |
| req_valid | input | 1 | Request present, held until accepted |
| req_ready | output | 1 | Sequencer can accept a request this cycle |
| req_addr | input | ADDR_W (15) | Word address of the request |
| req_src | input | SRC_W (2) | Source tag of the request |
| rsp_valid | output | 1 | Response word present (one cycle per word) |
| rsp_data | output | DATA_W (16) | Returned ROM word |
| rsp_src | output | SRC_W (2) | Tag of the returned word |
| rom_en | output | 1 | Read strobe to the synchronous ROM array |
| rom_addr | output | ADDR_W (15) | Word address to the ROM array |
| rom_data | input | DATA_W (16) | ROM array read data, valid the cycle after `rom_en` |

## Verification
The main timing is driven in four patterns, and each one separates a different latency rule.
- An isolated request from idle pins down the three-cycle first-access path.
- A run of back-to-back requests, with every tag value and the lowest and highest addresses, shows that only same-cycle continuation earns the two-cycle cost.
- A request issued one idle cycle after a response shows that a gap falls back to three cycles.
- The ROM-disable input is raised in two cases: mid-access, where the pending word must never appear, and while idle with a request pending, where the request must not be accepted. After the disable clears, the following access must again be a first access.

// File: rtl/rws_pkg.sv
package rws_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FIRST = 2'd1,
      ST_NEXT  = 2'd2,
      ST_DATA  = 2'd3
   } rws_state_e;

endpackage

// File: rtl/rws_wait_ctr.sv
module rws_wait_ctr #(
   parameter int MAX_WAIT = 2,
   parameter int CW       = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          last
);

   generate
      if (MAX_WAIT == 1) begin : g_flag
         logic busy_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     busy_q <= 1'b0;
            else if (clear) busy_q <= 1'b0;
            else            busy_q <= load && (load_val != '0);
         end
         assign last = busy_q;
      end else begin : g_count
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             cnt_q <= '0;
            else if (clear)         cnt_q <= '0;
            else if (load)          cnt_q <= load_val;
            else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
         end
         assign last = (cnt_q == CW'(1));

         // R2: remaining-wait count never exceeds the longest wait
         p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
            load |=> (cnt_q <= CW'(MAX_WAIT)));
      end
   endgenerate

endmodule

// File: rtl/rws_ctrl.sv
module rws_ctrl
   import rws_pkg::*;
#(
   parameter int FIRST_WAIT = 2,
   parameter int NEXT_WAIT  = 1,
   parameter int CW         = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rom_off,
   input  logic          req_valid,
   input  logic          wait_last,
   output logic          req_ready,
   output logic          accept,
   output logic          ld_en,
   output logic [CW-1:0] ld_val,
   output logic          ctr_clear,
   output logic          rom_en,
   output logic          rsp_valid
);

   rws_state_e state_q, state_d;
   logic       in_wait;

   always_comb begin
      in_wait   = (state_q == ST_FIRST) || (state_q == ST_NEXT);
      req_ready = !rom_off && ((state_q == ST_IDLE) || (state_q == ST_DATA));
      accept    = req_valid && req_ready;
      rsp_valid = (state_q == ST_DATA) && !rom_off;
      rom_en    = in_wait && wait_last && !rom_off;
      ld_en     = accept;
      ld_val    = (state_q == ST_DATA) ? CW'(NEXT_WAIT) : CW'(FIRST_WAIT);
      ctr_clear = rom_off;
   end

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (accept) state_d = ST_FIRST;
         ST_FIRST: if (wait_last) state_d = ST_DATA;
         ST_NEXT:  if (wait_last) state_d = ST_DATA;
         ST_DATA:  state_d = accept ? ST_NEXT : ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
      if (rom_off) state_d = ST_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   // R5: one response cycle per word
   p_valid_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R8: disable cancels any pending response
   p_abort_no_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rom_off |=> !rsp_valid);

   // R2: an access started from idle does not answer on the next cycle
   p_first_not_early_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !rsp_valid) |=> !rsp_valid);

endmodule

// File: rtl/rom_wait_seq.sv
module rom_wait_seq #(
   parameter int ADDR_W     = 15,
   parameter int DATA_W     = 16,
   parameter int SRC_W      = 2,
   parameter int FIRST_WAIT = 2,
   parameter int NEXT_WAIT  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rom_off,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [SRC_W-1:0]  req_src,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic [SRC_W-1:0]  rsp_src,
   output logic              rom_en,
   output logic [ADDR_W-1:0] rom_addr,
   input  logic [DATA_W-1:0] rom_data
);

   localparam int MAX_WAIT = (FIRST_WAIT > NEXT_WAIT) ? FIRST_WAIT : NEXT_WAIT;
   localparam int CW       = (MAX_WAIT < 2) ? 1 : $clog2(MAX_WAIT + 1);

   generate
      if (FIRST_WAIT < 1 || NEXT_WAIT < 1) begin : g_bad_wait
         $error("rom_wait_seq: wait counts must be at least 1");
      end
      if (NEXT_WAIT > FIRST_WAIT) begin : g_bad_order
         $error("rom_wait_seq: NEXT_WAIT must not exceed FIRST_WAIT");
      end
      if (ADDR_W < 1 || DATA_W < 1 || SRC_W < 1) begin : g_bad_width
         $error("rom_wait_seq: widths must be positive");
      end
   endgenerate

   logic          accept, ld_en, ctr_clear, wait_last;
   logic [CW-1:0] ld_val;
   logic [ADDR_W-1:0] addr_q;
   logic [SRC_W-1:0]  src_q;

   rws_ctrl #(
      .FIRST_WAIT(FIRST_WAIT),
      .NEXT_WAIT (NEXT_WAIT),
      .CW        (CW)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .rom_off  (rom_off),
      .req_valid(req_valid),
      .wait_last(wait_last),
      .req_ready(req_ready),
      .accept   (accept),
      .ld_en    (ld_en),
      .ld_val   (ld_val),
      .ctr_clear(ctr_clear),
      .rom_en   (rom_en),
      .rsp_valid(rsp_valid)
   );

   rws_wait_ctr #(
      .MAX_WAIT(MAX_WAIT),
      .CW      (CW)
   ) u_wait (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (ctr_clear),
      .load    (ld_en),
      .load_val(ld_val),
      .last    (wait_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         src_q  <= '0;
      end else if (accept) begin
         addr_q <= req_addr;
         src_q  <= req_src;
      end
   end

   assign rom_addr = addr_q;
   assign rsp_data = rom_data;
   assign rsp_src  = src_q;

   // R6: every response is preceded by a ROM strobe
   p_fetch_precedes_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(rom_en));

   // R6: a ROM strobe is followed by a response unless disabled
   p_fetch_then_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rom_en |=> (rsp_valid || rom_off));

endmodule

// File: tb/rom_wait_seq_bench.sv
module rom_wait_seq_bench;

   localparam int AW = 15;
   localparam int DW = 16;
   localparam int SW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rom_off = 1'b0;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [SW-1:0] req_src = '0;
   logic          req_ready, rsp_valid, rom_en;
   logic [DW-1:0] rsp_data, rom_q;
   logic [SW-1:0] rsp_src;
   logic [AW-1:0] rom_addr;

   always #10 clk = ~clk;

   rom_wait_seq u_rom_wait_seq (
      .clk(clk), .rst_n(rst_n), .rom_off(rom_off),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_src(req_src),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_src(rsp_src),
      .rom_en(rom_en), .rom_addr(rom_addr), .rom_data(rom_q)
   );

   function automatic logic [DW-1:0] romf(input logic [AW-1:0] a);
      logic [31:0] t;
      t = {17'd0, a} * 32'h9E37;
      return t[15:0] ^ 16'h5A5A;
   endfunction

   always @(posedge clk) if (rom_en) rom_q <= romf(rom_addr);

   typedef struct {
      int            cyc;
      logic [DW-1:0] data;
      logic [SW-1:0] src;
      string         rq;
   } item_t;

   item_t q[$];
   int cyc = 0;
   int checks = 0;
   int fails = 0;
   int last_exp = -1;
   bit done = 0;
   logic prev_v = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string rq, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   // monitor: compare responses against the scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (rsp_valid) begin
            check(!prev_v, "R5", "valid two cycles", 1, 0);
            if (q.size() == 0) begin
               check(0, "R8", "unexpected response", 1, 0);
            end else begin
               item_t it;
               it = q.pop_front();
               check(cyc == it.cyc, it.rq, "response cycle", cyc, it.cyc);
               check(rsp_data == it.data, "R6", "data", int'(rsp_data), int'(it.data));
               check(rsp_src == it.src, "R7", "source tag", int'(rsp_src), int'(it.src));
            end
         end
         prev_v = rsp_valid;
      end
   end

   // driver: call at a negedge; returns at a negedge with req_valid low
   task automatic issue(input logic [AW-1:0] a, input logic [SW-1:0] s, input string first_rq);
      item_t it;
      int lat;
      req_valid = 1'b1;
      req_addr  = a;
      req_src   = s;
      while (!req_ready) @(negedge clk);
      lat = (cyc == last_exp) ? 2 : 3;
      it.cyc  = cyc + lat;
      it.data = romf(a);
      it.src  = s;
      it.rq   = (lat == 2) ? "R3" : first_rq;
      q.push_back(it);
      last_exp = it.cyc;
      @(negedge clk);
      req_valid = 1'b0;
      check(req_ready == 1'b0, "R5", "ready in wait cycle", int'(req_ready), 0);
   endtask

   task automatic drain();
      while (cyc <= last_exp) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(rsp_valid == 1'b0, "R1", "reset rsp_valid", int'(rsp_valid), 0);
      check(req_ready == 1'b1, "R1", "reset req_ready", int'(req_ready), 1);
      check(rom_en == 1'b0, "R1", "reset rom_en", int'(rom_en), 0);

      // isolated first access
      issue(15'h0123, 2'd0, "R2");
      drain();
      repeat (2) @(negedge clk);

      // back-to-back run with every tag and edge addresses
      issue(15'h7FFF, 2'd1, "R2");
      issue(15'h0000, 2'd2, "R3");
      issue(15'h1234, 2'd3, "R3");
      issue(15'h4000, 2'd0, "R3");
      drain();

      // one idle cycle after a response restarts as first access
      issue(15'h0ABC, 2'd1, "R2");
      drain();
      issue(15'h0ABD, 2'd2, "R4");
      drain();
      @(negedge clk);

      // abort mid-access
      req_valid = 1'b1;
      req_addr  = 15'h2222;
      req_src   = 2'd2;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      rom_off   = 1'b1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check(rsp_valid == 1'b0, "R8", "valid during disable", int'(rsp_valid), 0);
         check(req_ready == 1'b0, "R8", "ready during disable", int'(req_ready), 0);
      end
      rom_off  = 1'b0;
      last_exp = -1;
      @(negedge clk);
      issue(15'h3333, 2'd3, "R9");
      issue(15'h3334, 2'd0, "R3");
      drain();
      @(negedge clk);

      // disable while idle with a request waiting: not accepted
      rom_off   = 1'b1;
      req_valid = 1'b1;
      req_addr  = 15'h5555;
      req_src   = 2'd1;
      @(negedge clk);
      check(req_ready == 1'b0, "R8", "ready while disabled", int'(req_ready), 0);
      @(negedge clk);
      req_valid = 1'b0;
      rom_off   = 1'b0;
      repeat (5) @(negedge clk);
      check(rsp_valid == 1'b0, "R8", "no response for blocked request", int'(rsp_valid), 0);

      // final run after re-enable
      issue(15'h6001, 2'd2, "R9");
      issue(15'h6002, 2'd1, "R3");
      drain();
      repeat (4) @(negedge clk);
      check(q.size() == 0, "R5", "missing responses", q.size(), 0);
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      finish_run();
   end

endmodule